// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on clocks that need not be related. Words enter on the write clock while the active-low write strobe is low. A read on the read clock, with the active-low read strobe low, loads the oldest stored word into a registered output. The output keeps its value between reads. No word reaches the output before a read requests it.

Five active-low level flags report how full the buffer is. The write side owns three of them: full, half-full and almost-full. The read side owns two: empty and almost-empty. A separate loader supplies the two threshold offsets as static inputs, and they may be changed while the buffer is idle. Each pointer crosses to the other domain in Gray code through a chain of synchronizer flops. A flag may therefore be late in showing space freed or data added by the other side, but it never reports more room or more data than really exists.

Each side runs a small state machine on the word count that the side itself sees. The write side has three states. WS_OPEN means the count is below the almost-full mark. WS_NEAR means the count is at or above DEPTH minus the full offset but not yet DEPTH. WS_FULL means the count equals DEPTH. The read side also has three states. RS_EMPTY means the count is zero. RS_SPARSE means the count is from 1 up to the empty offset. RS_FILLED means the count is above the empty offset. On every clock edge each machine moves to the state that matches the count after that edge's own access. Any state can move directly to any other state in the same machine. Reset forces WS_OPEN and RS_EMPTY.

Top module: `xcf_dual_clock_fifo`

## Requirements
- R1: A write is accepted on a rising `wclk` edge when `wen_n` is 0 and `full_n` is 1. A read is accepted on a rising `rclk` edge when `ren_n` is 0 and `empty_n` is 1. Each accepted read loads the oldest unread word onto `dout` at that edge, so words come out in the order they were written. `dout` does not change on edges without an accepted read.
- R2: `empty_n` goes to 1 within a few `rclk` edges after a write into an empty buffer. It goes to 0 at the `rclk` edge that reads the last word. A read request while `empty_n` is 0 changes neither `dout` nor the read position.
- R3: With no reads, `full_n` goes to 0 at the `wclk` edge of the DEPTH-th write. A write request while `full_n` is 0 is discarded and is never read out.
- R4: After one read from a full buffer, `full_n` returns to 1 within a few `wclk` edges.
- R5: `hf_n` is 0 while the write-side count is DEPTH/2+1 or more, and 1 at DEPTH/2 or less. For example, `hf_n` goes to 0 on the 129th stored word at depth 256.
- R6: `paf_n` is 0 while the write-side count is DEPTH minus `full_off` or more, and 1 below that.
- R7: `pae_n` is 0 while the read-side count is `empty_off` or less, and 1 once `empty_off`+1 words are stored.
- R8: While `rst_n` is 0, `empty_n`=0, `full_n`=1, `pae_n`=0, `hf_n`=1, `paf_n`=1 and `dout`=0.
- R9: Each pointer sent across the clock boundary changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wen_n | input | 1 | Active-low write strobe |
| din | input | WIDTH | Write data |
| ren_n | input | 1 | Active-low read strobe |
| dout | output | WIDTH | Registered read data |
| empty_off | input | AW | Almost-empty offset n |
| full_off | input | AW | Almost-full offset m |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| full_n | output | 1 | Active-low full flag (write domain) |
| hf_n | output | 1 | Active-low half-full flag (write domain) |
| pae_n | output | 1 | Active-low almost-empty flag (read domain) |
| paf_n | output | 1 | Active-low almost-full flag (write domain) |

## Verification
The hardest case to reach from the ports is a flag checked at an exact word count on the side opposite the traffic that changed it. Examples are `full_n` after a read, `hf_n` as the buffer drains, and `pae_n` as it fills. The true count is only visible after the synchronizer delay, so the bench moves the count one word at a time around each threshold. After each step it leaves both clocks running idle for several edges before it samples, so the value it reads has settled. It also keeps the write strobe low against a full buffer, drains every word, and confirms that none of the refused words appears at the output.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;

    // Write-side level classification
    typedef enum logic [1:0] {
        WS_OPEN = 2'd0,
        WS_NEAR = 2'd1,
        WS_FULL = 2'd2
    } wr_state_e;

    // Read-side level classification
    typedef enum logic [1:0] {
        RS_EMPTY  = 2'd0,
        RS_SPARSE = 2'd1,
        RS_FILLED = 2'd2
    } rd_state_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/xcf_gray_sync.sv
`timescale 1ns/1ps
module xcf_gray_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xcf_store.sv
`timescale 1ns/1ps
module xcf_store #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 18,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xcf_wr_ctrl.sv
`timescale 1ns/1ps
module xcf_wr_ctrl
    import xcf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic [AW-1:0] full_off,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          full_n,
    output logic          hf_n,
    output logic          paf_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP       = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_MARK = PW'(DEPTH / 2 + 1);

    wr_state_e       st_q, st_d;
    logic            half_q, half_d;
    logic [PW-1:0]   wbin_q, wbin_d, rbin_s, used_q, used_d, near_mark;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign we        = !wen_n && (st_q != WS_FULL);
    assign waddr     = wbin_q[AW-1:0];
    assign wbin_d    = wbin_q + PW'(we);
    assign rbin_s    = gray_to_bin(rgray_s);
    assign used_q    = wbin_q - rbin_s;
    assign used_d    = wbin_d - rbin_s;
    assign near_mark = CAP - {1'b0, full_off};

    // Next state: classify the count after this edge's write
    always_comb begin
        unique case (st_q)
            WS_OPEN, WS_NEAR, WS_FULL: begin
                if (used_d == CAP)            st_d = WS_FULL;
                else if (used_d >= near_mark) st_d = WS_NEAR;
                else                          st_d = WS_OPEN;
            end
            default:                          st_d = WS_OPEN;
        endcase
        half_d = (used_d >= HALF_MARK);
    end

    // State register and pointers
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WS_OPEN;
            half_q <= 1'b0;
            wbin_q <= '0;
            wgray  <= '0;
        end else begin
            st_q   <= st_d;
            half_q <= half_d;
            wbin_q <= wbin_d;
            wgray  <= wbin_d ^ (wbin_d >> 1);
        end
    end

    // Outputs from state
    always_comb begin
        unique case (st_q)
            WS_OPEN: begin full_n = 1'b1; paf_n = 1'b1; end
            WS_NEAR: begin full_n = 1'b1; paf_n = 1'b0; end
            WS_FULL: begin full_n = 1'b0; paf_n = 1'b0; end
            default: begin full_n = 1'b1; paf_n = 1'b1; end
        endcase
        hf_n = !half_q;
    end

    // R3: a refused write leaves the write pointer where it was
    a_r3_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wen_n) |=> $stable(wbin_q));
    // R3: the write side never sees more than DEPTH words
    a_r3_count_bound: assert property (@(posedge wclk) disable iff (!rst_n)
        used_q <= CAP);
    // R5/R6: full implies half-full and almost-full
    a_r5_full_implies_levels: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> (!hf_n && !paf_n));
    // R9: the exported pointer moves one Gray bit at most
    a_r9_wgray_one_bit: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/xcf_rd_ctrl.sv
`timescale 1ns/1ps
module xcf_rd_ctrl
    import xcf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic [AW-1:0] empty_off,
    input  logic [AW:0]   wgray_s,
    output logic [AW:0]   rgray,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic          empty_n,
    output logic          pae_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    rd_state_e       st_q, st_d;
    logic [PW-1:0]   rbin_q, rbin_d, wbin_s, used_q, used_d;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign re     = !ren_n && (st_q != RS_EMPTY);
    assign raddr  = rbin_q[AW-1:0];
    assign rbin_d = rbin_q + PW'(re);
    assign wbin_s = gray_to_bin(wgray_s);
    assign used_q = wbin_s - rbin_q;
    assign used_d = wbin_s - rbin_d;

    // Next state: classify the count after this edge's read
    always_comb begin
        unique case (st_q)
            RS_EMPTY, RS_SPARSE, RS_FILLED: begin
                if (used_d == '0)                   st_d = RS_EMPTY;
                else if (used_d <= {1'b0, empty_off}) st_d = RS_SPARSE;
                else                                st_d = RS_FILLED;
            end
            default:                                st_d = RS_EMPTY;
        endcase
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RS_EMPTY;
            rbin_q <= '0;
            rgray  <= '0;
        end else begin
            st_q   <= st_d;
            rbin_q <= rbin_d;
            rgray  <= rbin_d ^ (rbin_d >> 1);
        end
    end

    always_comb begin
        unique case (st_q)
            RS_EMPTY:  begin empty_n = 1'b0; pae_n = 1'b0; end
            RS_SPARSE: begin empty_n = 1'b1; pae_n = 1'b0; end
            RS_FILLED: begin empty_n = 1'b1; pae_n = 1'b1; end
            default:   begin empty_n = 1'b0; pae_n = 1'b0; end
        endcase
    end

    // R2: a refused read leaves the read pointer where it was
    a_r2_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !ren_n) |=> $stable(rbin_q));
    // R2: the read side never sees more than DEPTH words
    a_r2_count_bound: assert property (@(posedge rclk) disable iff (!rst_n)
        used_q <= CAP);
    // R7: empty implies almost-empty
    a_r7_empty_implies_pae: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !pae_n);
    // R9: the exported pointer moves one Gray bit at most
    a_r9_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rst_n)
        $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/xcf_dual_clock_fifo.sv
`timescale 1ns/1ps
module xcf_dual_clock_fifo
    import xcf_pkg::*;
#(
    parameter int  DEPTH = 256,
    parameter int  WIDTH = 18,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             wen_n,
    input  logic [WIDTH-1:0] din,
    input  logic             ren_n,
    output logic [WIDTH-1:0] dout,
    input  logic [AW-1:0]    empty_off,
    input  logic [AW-1:0]    full_off,
    output logic             empty_n,
    output logic             full_n,
    output logic             hf_n,
    output logic             pae_n,
    output logic             paf_n
);
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic          we, re;
    logic [AW-1:0] waddr, raddr;

    xcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .full_off(full_off),
        .rgray_s(rgray_s), .wgray(wgray), .we(we), .waddr(waddr),
        .full_n(full_n), .hf_n(hf_n), .paf_n(paf_n)
    );

    xcf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .empty_off(empty_off),
        .wgray_s(wgray_s), .rgray(rgray), .re(re), .raddr(raddr),
        .empty_n(empty_n), .pae_n(pae_n)
    );

    xcf_gray_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    xcf_gray_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    xcf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .rclk(rclk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(dout)
    );

    // R1: output only moves on an accepted read
    a_r1_dout_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren_n || !empty_n) |=> $stable(dout));
endmodule

// File: tb/xcf_dual_clock_fifo_tb_top.sv
`timescale 1ns/1ps
module xcf_dual_clock_fifo_tb_top;
    localparam int DEPTH = 256;
    localparam int WIDTH = 18;
    localparam int AW    = $clog2(DEPTH);
    localparam int DFLT  = (DEPTH <= 256) ? 31 : (DEPTH <= 512) ? 63 : 127;

    logic             wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic             wen_n = 1'b1, ren_n = 1'b1;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic [AW-1:0]    empty_off = AW'(DFLT), full_off = AW'(DFLT);
    logic             empty_n, full_n, hf_n, pae_n, paf_n;

    int n_tests = 0, n_fail = 0, wseq = 0;
    bit done = 0;
    logic [WIDTH-1:0] exp_q [$];

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    xcf_dual_clock_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
        .ren_n(ren_n), .dout(dout), .empty_off(empty_off), .full_off(full_off),
        .empty_n(empty_n), .full_n(full_n), .hf_n(hf_n), .pae_n(pae_n), .paf_n(paf_n)
    );

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL [%s] %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: pushes every word the design should accept
    task automatic wr_n(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge wclk);
            wen_n = 1'b0;
            din   = WIDTH'(wseq * 37) ^ 18'h2A5A5;
            wseq++;
            if (full_n) exp_q.push_back(din);
        end
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic rd_n(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge rclk);
            ren_n = 1'b0;
        end
        @(negedge rclk);
        ren_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    // Monitor: R1 ordering and data of every accepted read
    always @(posedge rclk) begin
        if (rst_n && !ren_n && empty_n) begin
            @(negedge rclk);
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL [R1] read with no expected word: actual=%0h expected=none", dout);
            end else begin
                check("R1", "read data", int'(dout), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL [R1] watchdog expired: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] held;
        #23;
        // R8 reset state
        check("R8", "empty_n in reset", int'(empty_n), 0);
        check("R8", "full_n in reset",  int'(full_n),  1);
        check("R8", "pae_n in reset",   int'(pae_n),   0);
        check("R8", "hf_n in reset",    int'(hf_n),    1);
        check("R8", "paf_n in reset",   int'(paf_n),   1);
        check("R8", "dout in reset",    int'(dout),    0);
        #30 rst_n = 1'b1;
        settle();

        // R2: single word in and out
        wr_n(1); settle();
        check("R2", "empty_n after first write", int'(empty_n), 1);
        check("R7", "pae_n with 1 word", int'(pae_n), 0);
        rd_n(1);
        check("R2", "empty_n after last read", int'(empty_n), 0);
        held = dout;
        rd_n(4); settle();
        check("R2", "dout unchanged by read while empty", int'(dout), int'(held));
        check("R2", "empty_n stays low", int'(empty_n), 0);

        // Fill one word at a time around each threshold
        wr_n(31); settle();
        check("R7", "pae_n at count n", int'(pae_n), 0);
        wr_n(1); settle();
        check("R7", "pae_n at count n+1", int'(pae_n), 1);
        wr_n(96);
        check("R5", "hf_n at D/2", int'(hf_n), 1);
        wr_n(1);
        check("R5", "hf_n at D/2+1", int'(hf_n), 0);
        wr_n(95);
        check("R6", "paf_n at D-m-1", int'(paf_n), 1);
        wr_n(1);
        check("R6", "paf_n at D-m", int'(paf_n), 0);
        wr_n(30);
        check("R3", "full_n at D-1", int'(full_n), 1);
        wr_n(1);
        check("R3", "full_n at D", int'(full_n), 0);
        wr_n(3);
        check("R3", "full_n after refused writes", int'(full_n), 0);

        // Drain around the same thresholds
        rd_n(1); settle();
        check("R4", "full_n after one read from full", int'(full_n), 1);
        rd_n(126); settle();
        check("R5", "hf_n at D/2+1 draining", int'(hf_n), 0);
        rd_n(1); settle();
        check("R5", "hf_n at D/2 draining", int'(hf_n), 1);
        check("R6", "paf_n at D/2 draining", int'(paf_n), 1);
        rd_n(96); settle();
        check("R7", "pae_n at n+1 draining", int'(pae_n), 1);
        rd_n(1);
        check("R7", "pae_n at n draining", int'(pae_n), 0);
        rd_n(31); settle();
        check("R2", "empty_n after full drain", int'(empty_n), 0);
        check("R3", "refused writes never read out", exp_q.size(), 0);

        // Runtime offsets n=5, m=10
        empty_off = AW'(5); full_off = AW'(10);
        settle();
        wr_n(5); settle();
        check("R7", "pae_n at n=5", int'(pae_n), 0);
        wr_n(1); settle();
        check("R7", "pae_n at 6 words", int'(pae_n), 1);
        wr_n(239);
        check("R6", "paf_n at 245 with m=10", int'(paf_n), 1);
        wr_n(1);
        check("R6", "paf_n at 246 with m=10", int'(paf_n), 0);
        rd_n(246); settle();
        check("R2", "empty_n after offset phase", int'(empty_n), 0);

        // Concurrent streaming
        fork
            wr_n(300);
            begin repeat (20) @(negedge rclk); rd_n(400); end
        join
        settle();
        rd_n(10); settle();
        check("R1", "all streamed words read", exp_q.size(), 0);
        check("R2", "empty_n after stream", int'(empty_n), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule